// File: doc/BRIEF.md
# Interleaved ADC capture merger

This block sits behind two interleaved flash converters. Each converter produces 8-bit codes on two output groups, A and B. Each converter sends its own data clock with the groups. Group A carries a new code after each rising edge of that clock, and group B carries one after each falling edge. The second converter samples half a conversion period after the first. Its data clock therefore lags by a quarter of a data-clock period. The block rebuilds the single time-ordered sample stream from the four groups. It packs four samples into one wide word and hands each word to a downstream buffer modelled as a ready/valid sink.

All logic runs on one fast system clock. Each data clock is treated as data: it is passed through a short synchronizer together with its buses, and its edges are detected in the system clock domain. A mode input selects full-rate output or a decimated stream that keeps one sample in five. A mode change never splits a word. The first word packed after a change carries a resync flag. A word that completes while the sink is not ready is lost, and a sticky overflow flag records the loss until software clears it.

Top module: `ilv_capture`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is asserted, `valid_o` and `ovf_o` are 0. Reset also discards any partly packed word and returns the block to full-rate mode.
- R2: A group A code is taken only on a rising edge of its converter's data clock. A group B code is taken only on a falling edge. Values present on a bus at any other time never reach the output.
- R3: At full rate, the samples of one data-clock period are merged in this order: converter 0 A, converter 1 A, converter 0 B, converter 1 B. They are packed into `word_o` with the earliest sample in bits [7:0] and the latest in bits [31:24]. Each word is presented with a one-cycle `valid_o` pulse.
- R4: With `decim_i` = 1 in effect, the merged samples are numbered from 0, starting with the first sample after the mode took effect. Only samples 0, 5, 10, … are kept. The kept samples are packed four per word in the same byte order as R3.
- R5: A new value on `decim_i` takes effect only while no samples of an unfinished word are held. Samples already held finish their word under the previous mode.
- R6: `resync_o` is 1 on the first completed word after the mode has actually changed. This holds even if that word is dropped by R7, in which case the flag is consumed. On all other words `resync_o` is 0.
- R7: If `ready_i` is low in the cycle a word completes, the word is dropped, `valid_o` stays low, and `ovf_o` becomes 1 in the next cycle.
- R8: `ovf_o` stays 1 until `ovf_clr_i` is high for a cycle, after which it is 0. A clear wins over an overflow in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk_i | input | 2 | Data clock of each converter, bit c for converter c |
| grp_a_i | input | 16 | Group A buses, converter c in bits [8c+7:8c] |
| grp_b_i | input | 16 | Group B buses, converter c in bits [8c+7:8c] |
| decim_i | input | 1 | 1 selects the one-in-five decimated stream, 0 full rate |
| ready_i | input | 1 | Downstream sink can take a word this cycle |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| word_o | output | 32 | Packed word of four samples |
| valid_o | output | 1 | One-cycle strobe marking `word_o` valid |
| resync_o | output | 1 | Set on the first word after a mode change |
| ovf_o | output | 1 | Sticky flag: a word was dropped |

## Verification
The bench uses the default parameters: two converters, 8-bit samples, four samples per word, a decimation ratio of five and a two-stage synchronizer. These settings make the whole ordering and byte layout visible in each 32-bit word. Each data-clock period lasts 32 system cycles, so every group update reaches the packer on its own. Meanwhile the opposite bus of each converter is driven with junk to show that only the proper edge captures a value. Twenty decimated periods yield four decimated words, which is enough to see the one-in-five pattern cross several word boundaries. The mode switch in both directions exercises the boundary rule and the resync flag.

// File: rtl/ilvc_pkg.sv
package ilvc_pkg;
    localparam int SAMPLE_W   = 8;
    localparam int N_CONV     = 2;
    localparam int WORD_LANES = 4;
    localparam int DECIM_RATIO = 5;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_DECIM = 1'b1
    } mode_e;
endpackage

// File: rtl/ilvc_edge_cap.sv
module ilvc_edge_cap #(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dclk_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         a_stb_o,
    output logic         b_stb_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    typedef struct packed {
        logic [SYNC-1:0]        ck;
        logic [SYNC-1:0][W-1:0] a;
        logic [SYNC-1:0][W-1:0] b;
        logic                   ck_prev;
        logic                   a_stb;
        logic                   b_stb;
        logic [W-1:0]           a_out;
        logic [W-1:0]           b_out;
    } cap_t;

    cap_t cap_d, cap_q;
    logic ck_now, rise, fall;

    always_comb begin
        cap_d       = cap_q;
        cap_d.ck[0] = dclk_i;
        cap_d.a[0]  = a_i;
        cap_d.b[0]  = b_i;
        for (int i = 1; i < SYNC; i++) begin
            cap_d.ck[i] = cap_q.ck[i-1];
            cap_d.a[i]  = cap_q.a[i-1];
            cap_d.b[i]  = cap_q.b[i-1];
        end
        ck_now        = cap_q.ck[SYNC-1];
        rise          = ck_now & ~cap_q.ck_prev;
        fall          = ~ck_now & cap_q.ck_prev;
        cap_d.ck_prev = ck_now;
        cap_d.a_stb   = rise;
        cap_d.b_stb   = fall;
        if (rise) cap_d.a_out = cap_q.a[SYNC-1];
        if (fall) cap_d.b_out = cap_q.b[SYNC-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign a_stb_o = cap_q.a_stb;
    assign b_stb_o = cap_q.b_stb;
    assign a_o     = cap_q.a_out;
    assign b_o     = cap_q.b_out;

    // R2: one level change gives exactly one strobe
    p_a_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_stb_o |=> !a_stb_o);
    p_ab_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_stb_o, b_stb_o}));
endmodule

// File: rtl/ilvc_merge.sv
module ilvc_merge #(
    parameter int W     = 8,
    parameter int SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       in_stb_i,
    input  logic [SLOTS-1:0][W-1:0] in_data_i,
    output logic                   out_stb_o,
    output logic [W-1:0]           out_data_o
);
    localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          stb;
        logic [W-1:0]  data;
    } mrg_t;

    mrg_t mrg_d, mrg_q;

    always_comb begin
        mrg_d     = mrg_q;
        mrg_d.stb = 1'b0;
        if (in_stb_i[mrg_q.ptr]) begin
            mrg_d.stb  = 1'b1;
            mrg_d.data = in_data_i[mrg_q.ptr];
            mrg_d.ptr  = (mrg_q.ptr == PW'(SLOTS-1)) ? '0 : mrg_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mrg_q <= '0;
        else        mrg_q <= mrg_d;
    end

    assign out_stb_o  = mrg_q.stb;
    assign out_data_o = mrg_q.data;

    // R3: a merged sample always comes from a captured group update
    p_out_needs_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb_o |-> $past(|in_stb_i));
endmodule

// File: rtl/ilvc_packer.sv
module ilvc_packer
    import ilvc_pkg::*;
#(
    parameter int W     = 8,
    parameter int LANES = 4,
    parameter int DECIM = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_stb_i,
    input  logic [W-1:0]       smp_i,
    input  logic               decim_i,
    input  logic               ready_i,
    input  logic               ovf_clr_i,
    output logic [W*LANES-1:0] word_o,
    output logic               valid_o,
    output logic               resync_o,
    output logic               ovf_o
);
    localparam int CW = $clog2(LANES);
    localparam int DW = $clog2(DECIM);

    typedef struct packed {
        logic [LANES-1:0][W-1:0] lanes;
        logic [CW-1:0]           cnt;
        logic [DW-1:0]           dcnt;
        mode_e                   mode;
        logic                    pend;
        logic [W*LANES-1:0]      word;
        logic                    valid;
        logic                    resync;
        logic                    ovf;
    } pk_t;

    pk_t pk_d, pk_q;
    logic keep, boundary;

    always_comb begin
        pk_d        = pk_q;
        pk_d.valid  = 1'b0;
        pk_d.resync = 1'b0;
        boundary    = (pk_q.cnt == '0) && !smp_stb_i;
        keep        = 1'b0;

        if (boundary && (mode_e'(decim_i) != pk_q.mode)) begin
            pk_d.mode = mode_e'(decim_i);
            pk_d.pend = 1'b1;
            pk_d.dcnt = '0;
        end

        if (smp_stb_i) begin
            keep = (pk_q.mode == MODE_FULL) || (pk_q.dcnt == '0);
            if (pk_q.mode == MODE_DECIM)
                pk_d.dcnt = (pk_q.dcnt == DW'(DECIM-1)) ? '0 : pk_q.dcnt + 1'b1;
            else
                pk_d.dcnt = '0;
            if (keep) begin
                pk_d.lanes[pk_q.cnt] = smp_i;
                if (pk_q.cnt == CW'(LANES-1)) begin
                    pk_d.cnt  = '0;
                    pk_d.pend = 1'b0;
                    if (ready_i) begin
                        pk_d.word   = pk_d.lanes;
                        pk_d.valid  = 1'b1;
                        pk_d.resync = pk_q.pend;
                    end else begin
                        pk_d.ovf = 1'b1;
                    end
                end else begin
                    pk_d.cnt = pk_q.cnt + 1'b1;
                end
            end
        end

        if (ovf_clr_i) pk_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_o   = pk_q.word;
    assign valid_o  = pk_q.valid;
    assign resync_o = pk_q.resync;
    assign ovf_o    = pk_q.ovf;

    p_valid_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(ready_i));
    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr_i |=> !ovf_o);
    p_mode_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.mode != $past(pk_q.mode)) |-> ($past(pk_q.cnt) == '0));
endmodule

// File: rtl/ilv_capture.sv
module ilv_capture
    import ilvc_pkg::*;
#(
    parameter int W     = SAMPLE_W,
    parameter int NCONV = N_CONV,
    parameter int LANES = WORD_LANES,
    parameter int DECIM = DECIM_RATIO,
    parameter int SYNC  = SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCONV-1:0]   dclk_i,
    input  logic [NCONV*W-1:0] grp_a_i,
    input  logic [NCONV*W-1:0] grp_b_i,
    input  logic               decim_i,
    input  logic               ready_i,
    input  logic               ovf_clr_i,
    output logic [W*LANES-1:0] word_o,
    output logic               valid_o,
    output logic               resync_o,
    output logic               ovf_o
);
    localparam int SLOTS = 2 * NCONV;

    logic [SLOTS-1:0]        slot_stb;
    logic [SLOTS-1:0][W-1:0] slot_data;
    logic                    smp_stb;
    logic [W-1:0]            smp;

    // slot order: all A groups by converter, then all B groups
    for (genvar c = 0; c < NCONV; c++) begin : g_conv
        ilvc_edge_cap #(.W(W), .SYNC(SYNC)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .dclk_i  (dclk_i[c]),
            .a_i     (grp_a_i[c*W +: W]),
            .b_i     (grp_b_i[c*W +: W]),
            .a_stb_o (slot_stb[c]),
            .b_stb_o (slot_stb[NCONV+c]),
            .a_o     (slot_data[c]),
            .b_o     (slot_data[NCONV+c])
        );
    end

    ilvc_merge #(.W(W), .SLOTS(SLOTS)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_stb_i   (slot_stb),
        .in_data_i  (slot_data),
        .out_stb_o  (smp_stb),
        .out_data_o (smp)
    );

    ilvc_packer #(.W(W), .LANES(LANES), .DECIM(DECIM)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb_i (smp_stb),
        .smp_i     (smp),
        .decim_i   (decim_i),
        .ready_i   (ready_i),
        .ovf_clr_i (ovf_clr_i),
        .word_o    (word_o),
        .valid_o   (valid_o),
        .resync_o  (resync_o),
        .ovf_o     (ovf_o)
    );
endmodule

// File: tb/tb_ilv_capture.sv
module tb_ilv_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dclk = '0;
    logic [15:0] ga = '0, gb = '0;
    logic        decim = 1'b0, ready = 1'b1, clr = 1'b0;
    logic [31:0] word;
    logic        valid, resync, ovf;

    ilv_capture dut (
        .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .grp_a_i(ga), .grp_b_i(gb),
        .decim_i(decim), .ready_i(ready), .ovf_clr_i(clr),
        .word_o(word), .valid_o(valid), .resync_o(resync), .ovf_o(ovf)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, got_words = 0, exp_words = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R3";

    int          m_cnt = 0, m_dcnt = 0;
    logic        m_mode = 1'b0, m_pend = 1'b0, m_rs = 1'b0;
    logic [31:0] m_word = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v);
        bit keep;
        if (m_pend != m_mode && m_cnt == 0) begin
            m_mode = m_pend; m_rs = 1'b1; m_dcnt = 0;
        end
        keep = !m_mode || m_dcnt == 0;
        if (m_mode) m_dcnt = (m_dcnt == 4) ? 0 : m_dcnt + 1;
        else        m_dcnt = 0;
        if (keep) begin
            m_word[m_cnt*8 +: 8] = v;
            m_cnt++;
            if (m_cnt == 4) begin
                m_cnt = 0;
                if (ready) begin
                    exp_q.push_back({m_rs, m_word});
                    tag_q.push_back(m_rs ? "R5 R6" : cur_tag);
                    exp_words++;
                end
                m_rs = 1'b0;
            end
        end
    endtask

    function automatic logic [7:0] val(input int k, input int j);
        return 8'((k * 4 + j) * 29 + 11);
    endfunction

    task automatic period(input int k, input logic rdy, input logic mode_after);
        for (int ph = 0; ph < 32; ph++) begin
            @(negedge clk);
            case (ph)
                0:  begin dclk[0] = 1'b1; ga[7:0] = val(k,0); gb[7:0] = ~val(k,0); push(val(k,0)); end
                8:  begin dclk[1] = 1'b1; ga[15:8] = val(k,1); gb[15:8] = val(k,1) ^ 8'h5A; push(val(k,1)); end
                16: begin dclk[0] = 1'b0; gb[7:0] = val(k,2); ga[7:0] = val(k,2) + 8'd3; push(val(k,2)); end
                18: ready = rdy;
                24: begin dclk[1] = 1'b0; gb[15:8] = val(k,3); ga[15:8] = ~val(k,3); push(val(k,3)); end
                28: begin decim = mode_after; m_pend = mode_after; end
                default: ;
            endcase
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid) begin
            got_words++;
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected word", {resync, word}, '0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({resync, word} == e, t, "word", {resync, word}, e);
            end
        end
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        chk(valid == 1'b0, "R1", "valid in reset", {32'b0, valid}, '0);
        chk(ovf == 1'b0, "R1", "ovf in reset", {32'b0, ovf}, '0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        cur_tag = "R2";
        repeat (2) begin period(k, 1'b1, 1'b0); k++; end
        cur_tag = "R3";
        repeat (3) begin period(k, 1'b1, 1'b0); k++; end

        // R7: sink busy drops one word
        cur_tag = "R7";
        period(k, 1'b0, 1'b0); k++;
        chk(ovf == 1'b1, "R7", "ovf after drop", {32'b0, ovf}, 33'd1);
        period(k, 1'b1, 1'b0); k++;
        chk(ovf == 1'b1, "R8", "ovf sticky", {32'b0, ovf}, 33'd1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(ovf == 1'b0, "R8", "ovf cleared", {32'b0, ovf}, '0);

        // R4 R5 R6: switch to decimated mode and back
        cur_tag = "R3";
        period(k, 1'b1, 1'b1); k++;
        cur_tag = "R4";
        for (int i = 0; i < 20; i++) begin
            period(k, 1'b1, (i == 19) ? 1'b0 : 1'b1); k++;
        end
        cur_tag = "R3";
        repeat (2) begin period(k, 1'b1, 1'b0); k++; end
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "words outstanding", exp_q.size(), '0);
        chk(got_words == exp_words, "R4", "word count", got_words, exp_words);

        // R1: reset clears a set overflow flag
        period(k, 1'b0, 1'b0); k++;
        chk(ovf == 1'b1, "R7", "ovf before reset", {32'b0, ovf}, 33'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ovf == 1'b0, "R1", "ovf after reset", {32'b0, ovf}, '0);
        chk(valid == 1'b0, "R1", "valid after reset", {32'b0, valid}, '0);

        summary();
        $finish;
    end
endmodule